// File: doc/BRIEF.md
# Per-Destination Congestion Window Controller with Buffer Marker

This block keeps the source-side transmission windows for a set of destinations and also holds the switch-side logic that marks congestion. Each destination has two values, counted in flits. The first is a window limit. The second is the number of flits sent but not yet acknowledged. A packet to a destination is admitted only when its size fits in the space still left under that destination's limit. An admitted packet adds its size to the outstanding count. A positive acknowledgement later removes the same size.

An acknowledgement can carry the congestion mark. When it does, that destination's limit shrinks to four fifths of its current value, rounded down. The limit never goes below one maximum-size packet of 24 flits. While a limit is below its 4096-flit ceiling, a free-running timer adds one flit to it every 30 cycles, until the ceiling is reached again.

The marker compares an input buffer's fill level with half of its capacity. While the fill level is above that half, the buffer counts as congested, and every packet passing through leaves with its mark bit set. The destination copies that bit into its acknowledgement, and the acknowledgement comes back to the window logic here.

Injection is a valid/ready stream. `inj_ready` is a function of `inj_dest` and `inj_size` only. A packet transfers on a cycle where both `inj_valid` and `inj_ready` are high. The sender may hold a packet with `inj_valid` high for any number of cycles while `inj_ready` stays low, and nothing is counted in those cycles. Acknowledgements are never back-pressured: one is consumed on every cycle that `ack_valid` is high.

Top module: `ecn_window_ctrl`

## Requirements
- R1: After reset, every destination has a limit of 4096 flits and an outstanding count of 0.
- R2: `inj_ready` is high exactly when outstanding + `inj_size` <= limit for `inj_dest`. An accepted packet adds `inj_size` to that destination's outstanding count on the next clock edge. A packet that is held while not ready changes nothing.
- R3: An acknowledgement with `ack_pos`=1 subtracts `ack_size` from the outstanding count, saturating at 0. With `ack_pos`=0 the count is unchanged.
- R4: An acknowledgement with `ack_ecn`=1, positive or negative, sets that destination's limit to max(floor(limit*4/5), 24) on the next edge.
- R5: While a limit is below 4096, it rises by exactly 1 every 30 cycles. The first rise comes 30 edges after the edge that lowered it from 4096. A limit never rises above 4096.
- R6: When a marked acknowledgement and a timer increment fall on the same edge, only the reduction is applied.
- R7: A marked acknowledgement does not restart the regrowth timer; the next increment keeps its original phase.
- R8: `congested` is high exactly when `buf_occ` > BUF_CAP/2, and `fwd_ecn_o` = `fwd_ecn_i` OR `congested`.
- R9: Traffic and acknowledgements for one destination leave every other destination's limit and outstanding count untouched.
- R10: An injection and a positive acknowledgement for the same destination on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inj_valid | input | 1 | A packet is offered for injection |
| inj_ready | output | 1 | The offered packet fits in its destination's window |
| inj_dest | input | DEST_W | Destination of the offered packet |
| inj_size | input | SIZE_W | Size of the offered packet in flits (1..24) |
| ack_valid | input | 1 | An acknowledgement is present this cycle |
| ack_dest | input | DEST_W | Destination the acknowledgement refers to |
| ack_size | input | SIZE_W | Flit size of the acknowledged packet |
| ack_pos | input | 1 | 1 = positive acknowledgement, 0 = negative |
| ack_ecn | input | 1 | Congestion mark copied back by the destination |
| q_dest | input | DEST_W | Destination whose window is shown on the query outputs |
| q_limit | output | LIM_W | Current limit of `q_dest` |
| q_occ | output | LIM_W | Current outstanding flit count of `q_dest` |
| buf_occ | input | BUF_W | Fill level of the watched input buffer |
| fwd_ecn_i | input | 1 | Mark bit of the packet entering the marker |
| fwd_ecn_o | output | 1 | Mark bit of the packet leaving the marker |
| congested | output | 1 | The watched buffer is above half full |

## Verification
The bench builds the block with four destinations and a 64-entry marker buffer. It keeps the full-scale constants: a 4096-flit ceiling, a 24-flit floor and a 30-cycle regrowth period. With these values a window can be filled to exactly its limit in about 170 packets. The floor is reached after roughly two dozen marked acknowledgements. A full regrowth from 3276 back to the ceiling takes under 25,000 cycles. This keeps the saturation edges, the tick and reduction collision and the half-full boundary of the marker all within one run.

// File: rtl/ecnw_pkg.sv
package ecnw_pkg;

  localparam int WIN_MAX_DEF  = 4096;
  localparam int PKT_MAX_DEF  = 24;
  localparam int PERIOD_DEF   = 30;
  localparam int DEC_NUM_DEF  = 4;
  localparam int DEC_DEN_DEF  = 5;

  // What happens to a destination limit on a clock edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_SHRINK = 2'd1,
    ACT_GROW   = 2'd2
  } win_act_e;

endpackage

// File: rtl/ecnw_slot.sv
module ecnw_slot
  import ecnw_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int DEST_W  = 2,
  parameter int SIZE_W  = 5,
  parameter int LIM_W   = 13,
  parameter int WIN_MAX = WIN_MAX_DEF,
  parameter int FLOOR   = PKT_MAX_DEF,
  parameter int PERIOD  = PERIOD_DEF,
  parameter int DEC_NUM = DEC_NUM_DEF,
  parameter int DEC_DEN = DEC_DEN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_fire,
  input  logic [DEST_W-1:0] inj_dest,
  input  logic [SIZE_W-1:0] inj_size,
  input  logic              ack_valid,
  input  logic [DEST_W-1:0] ack_dest,
  input  logic [SIZE_W-1:0] ack_size,
  input  logic              ack_pos,
  input  logic              ack_ecn,
  output logic [LIM_W-1:0]  limit,
  output logic [LIM_W-1:0]  occ
);

  localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int PROD_W = LIM_W + $clog2(DEC_NUM + 1);

  logic [CNT_W-1:0]  tick_cnt;
  logic              inj_hit, ack_hit;
  logic [LIM_W:0]    occ_sum, occ_sub;
  logic [LIM_W-1:0]  occ_next;
  logic [PROD_W-1:0] prod, scaled;
  logic [LIM_W-1:0]  shrunk;
  logic              below_max, tick;
  win_act_e          act;

  assign inj_hit = inj_fire  && (inj_dest == DEST_W'(IDX));
  assign ack_hit = ack_valid && (ack_dest == DEST_W'(IDX));

  // Outstanding count: add on injection, subtract on positive ack, clamp at zero
  always_comb begin
    occ_sum  = {1'b0, occ} + (inj_hit ? (LIM_W+1)'(inj_size) : '0);
    occ_sub  = (ack_hit && ack_pos) ? (LIM_W+1)'(ack_size) : '0;
    occ_next = (occ_sum >= occ_sub) ? LIM_W'(occ_sum - occ_sub) : '0;
  end

  // Multiplicative decrease with a one-packet floor
  always_comb begin
    prod   = PROD_W'(limit) * PROD_W'(DEC_NUM);
    scaled = prod / PROD_W'(DEC_DEN);
    shrunk = (scaled < PROD_W'(FLOOR)) ? LIM_W'(FLOOR) : LIM_W'(scaled);
  end

  assign below_max = (limit < LIM_W'(WIN_MAX));
  assign tick      = below_max && (tick_cnt == CNT_W'(PERIOD - 1));

  always_comb begin
    if (ack_hit && ack_ecn) act = ACT_SHRINK;
    else if (tick)          act = ACT_GROW;
    else                    act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit    <= LIM_W'(WIN_MAX);
      occ      <= '0;
      tick_cnt <= '0;
    end else begin
      occ <= occ_next;
      // timer phase runs freely while below the ceiling
      if (!below_max)  tick_cnt <= '0;
      else if (tick)   tick_cnt <= '0;
      else             tick_cnt <= tick_cnt + CNT_W'(1);
      case (act)
        ACT_SHRINK: limit <= shrunk;
        ACT_GROW:   limit <= limit + LIM_W'(1);
        default:    limit <= limit;
      endcase
    end
  end

endmodule

// File: rtl/ecnw_admit.sv
module ecnw_admit #(
  parameter int NUM_DEST = 4,
  parameter int DEST_W   = 2,
  parameter int SIZE_W   = 5,
  parameter int LIM_W    = 13
) (
  input  logic [NUM_DEST-1:0][LIM_W-1:0] lim_v,
  input  logic [NUM_DEST-1:0][LIM_W-1:0] occ_v,
  input  logic [DEST_W-1:0]              inj_dest,
  input  logic [SIZE_W-1:0]              inj_size,
  input  logic [DEST_W-1:0]              q_dest,
  output logic                           inj_ready,
  output logic [LIM_W-1:0]               q_limit,
  output logic [LIM_W-1:0]               q_occ
);

  logic [LIM_W-1:0] sel_lim, sel_occ;
  logic [LIM_W:0]   need;

  assign sel_lim   = lim_v[inj_dest];
  assign sel_occ   = occ_v[inj_dest];
  assign need      = {1'b0, sel_occ} + (LIM_W+1)'(inj_size);
  assign inj_ready = (need <= {1'b0, sel_lim});

  assign q_limit = lim_v[q_dest];
  assign q_occ   = occ_v[q_dest];

endmodule

// File: rtl/ecnw_marker.sv
module ecnw_marker #(
  parameter int BUF_CAP = 64,
  parameter int BUF_W   = 7
) (
  input  logic [BUF_W-1:0] buf_occ,
  input  logic             fwd_ecn_i,
  output logic             fwd_ecn_o,
  output logic             congested
);

  localparam int HALF = BUF_CAP / 2;

  assign congested = (buf_occ > BUF_W'(HALF));
  assign fwd_ecn_o = fwd_ecn_i | congested;

endmodule

// File: rtl/ecn_window_ctrl.sv
module ecn_window_ctrl
  import ecnw_pkg::*;
#(
  parameter int NUM_DEST = 4,
  parameter int WIN_MAX  = WIN_MAX_DEF,
  parameter int PKT_MAX  = PKT_MAX_DEF,
  parameter int PERIOD   = PERIOD_DEF,
  parameter int DEC_NUM  = DEC_NUM_DEF,
  parameter int DEC_DEN  = DEC_DEN_DEF,
  parameter int BUF_CAP  = 64,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int SIZE_W  = $clog2(PKT_MAX + 1),
  localparam int LIM_W   = $clog2(WIN_MAX + 1),
  localparam int BUF_W   = $clog2(BUF_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [DEST_W-1:0] inj_dest,
  input  logic [SIZE_W-1:0] inj_size,
  input  logic              ack_valid,
  input  logic [DEST_W-1:0] ack_dest,
  input  logic [SIZE_W-1:0] ack_size,
  input  logic              ack_pos,
  input  logic              ack_ecn,
  input  logic [DEST_W-1:0] q_dest,
  output logic [LIM_W-1:0]  q_limit,
  output logic [LIM_W-1:0]  q_occ,
  input  logic [BUF_W-1:0]  buf_occ,
  input  logic              fwd_ecn_i,
  output logic              fwd_ecn_o,
  output logic              congested
);

  logic [NUM_DEST-1:0][LIM_W-1:0] lim_v;
  logic [NUM_DEST-1:0][LIM_W-1:0] occ_v;
  logic                           inj_fire;

  assign inj_fire = inj_valid && inj_ready;

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_slot
    ecnw_slot #(
      .IDX(d), .DEST_W(DEST_W), .SIZE_W(SIZE_W), .LIM_W(LIM_W),
      .WIN_MAX(WIN_MAX), .FLOOR(PKT_MAX), .PERIOD(PERIOD),
      .DEC_NUM(DEC_NUM), .DEC_DEN(DEC_DEN)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .inj_fire(inj_fire), .inj_dest(inj_dest), .inj_size(inj_size),
      .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_size(ack_size),
      .ack_pos(ack_pos), .ack_ecn(ack_ecn),
      .limit(lim_v[d]), .occ(occ_v[d])
    );
  end

  ecnw_admit #(
    .NUM_DEST(NUM_DEST), .DEST_W(DEST_W), .SIZE_W(SIZE_W), .LIM_W(LIM_W)
  ) u_admit (
    .lim_v(lim_v), .occ_v(occ_v),
    .inj_dest(inj_dest), .inj_size(inj_size), .q_dest(q_dest),
    .inj_ready(inj_ready), .q_limit(q_limit), .q_occ(q_occ)
  );

  ecnw_marker #(.BUF_CAP(BUF_CAP), .BUF_W(BUF_W)) u_marker (
    .buf_occ(buf_occ), .fwd_ecn_i(fwd_ecn_i),
    .fwd_ecn_o(fwd_ecn_o), .congested(congested)
  );

endmodule

// File: rtl/ecn_window_ctrl_chk.sv
module ecn_window_ctrl_chk #(
  parameter int NUM_DEST = 4,
  parameter int WIN_MAX  = 4096,
  parameter int PKT_MAX  = 24,
  parameter int DEST_W   = 2,
  parameter int SIZE_W   = 5,
  parameter int LIM_W    = 13
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           inj_valid,
  input logic                           inj_ready,
  input logic [DEST_W-1:0]              inj_dest,
  input logic [SIZE_W-1:0]              inj_size,
  input logic                           ack_valid,
  input logic [DEST_W-1:0]              ack_dest,
  input logic                           ack_ecn,
  input logic                           congested,
  input logic                           fwd_ecn_o,
  input logic [NUM_DEST-1:0][LIM_W-1:0] lim_v,
  input logic [NUM_DEST-1:0][LIM_W-1:0] occ_v
);

  // R1: the edge after a reset cycle shows every window at its start values
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (lim_v == {NUM_DEST{LIM_W'(WIN_MAX)}}) && (occ_v == '0));

  // R8: a congested buffer always forwards a marked packet
  p_mark_congested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    congested |-> fwd_ecn_o);

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_chk
    // R4: limit stays between the one-packet floor and the ceiling
    p_limit_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_v[d] >= LIM_W'(PKT_MAX)) && (lim_v[d] <= LIM_W'(WIN_MAX)));

    // R5: a limit only ever grows by a single flit per edge
    p_grow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_v[d] > $past(lim_v[d])) |-> (lim_v[d] == $past(lim_v[d]) + LIM_W'(1)));

    // R6: a marked ack never lets the limit rise on that edge
    p_no_grow_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_ecn && ack_dest == DEST_W'(d)) |=> (lim_v[d] <= $past(lim_v[d])));

    // R2: an accepted packet with no ack to the same destination raises the count by its size
    p_inject_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_valid && inj_ready && inj_dest == DEST_W'(d) &&
       !(ack_valid && ack_dest == DEST_W'(d)))
      |=> (occ_v[d] == $past(occ_v[d]) + LIM_W'($past(inj_size))));

    // R2: outstanding count never exceeds the ceiling
    p_occ_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      occ_v[d] <= LIM_W'(WIN_MAX));
  end

endmodule

bind ecn_window_ctrl ecn_window_ctrl_chk #(
  .NUM_DEST(NUM_DEST), .WIN_MAX(WIN_MAX), .PKT_MAX(PKT_MAX),
  .DEST_W(DEST_W), .SIZE_W(SIZE_W), .LIM_W(LIM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .inj_valid(inj_valid), .inj_ready(inj_ready),
  .inj_dest(inj_dest), .inj_size(inj_size),
  .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_ecn(ack_ecn),
  .congested(congested), .fwd_ecn_o(fwd_ecn_o),
  .lim_v(lim_v), .occ_v(occ_v)
);

// File: tb/tb_ecn_window_ctrl.sv
`timescale 1ns/1ps
module tb_ecn_window_ctrl;

  localparam int ND = 4;
  localparam int MAXW = 4096;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inj_valid;
  logic       inj_ready;
  logic [1:0] inj_dest;
  logic [4:0] inj_size;
  logic       ack_valid;
  logic [1:0] ack_dest;
  logic [4:0] ack_size;
  logic       ack_pos;
  logic       ack_ecn;
  logic [1:0] q_dest;
  logic [12:0] q_limit;
  logic [12:0] q_occ;
  logic [6:0] buf_occ;
  logic       fwd_ecn_i;
  logic       fwd_ecn_o;
  logic       congested;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ecn_window_ctrl #(.NUM_DEST(ND), .BUF_CAP(64)) dut (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_dest(inj_dest), .inj_size(inj_size),
    .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_size(ack_size),
    .ack_pos(ack_pos), .ack_ecn(ack_ecn),
    .q_dest(q_dest), .q_limit(q_limit), .q_occ(q_occ),
    .buf_occ(buf_occ), .fwd_ecn_i(fwd_ecn_i),
    .fwd_ecn_o(fwd_ecn_o), .congested(congested)
  );

  // Vector: [31:30] op (0 inject, 1 positive ack, 2 negative ack),
  // [29:28] destination, [27:20] size, [15:0] expected outstanding count
  localparam logic [31:0] VEC [8] = '{
    {2'd0, 2'd0, 8'd24, 4'd0, 16'd24},
    {2'd0, 2'd1, 8'd10, 4'd0, 16'd10},
    {2'd0, 2'd0, 8'd8,  4'd0, 16'd32},
    {2'd1, 2'd0, 8'd24, 4'd0, 16'd8},
    {2'd2, 2'd1, 8'd10, 4'd0, 16'd10},
    {2'd1, 2'd1, 8'd10, 4'd0, 16'd0},
    {2'd0, 2'd3, 8'd1,  4'd0, 16'd1},
    {2'd1, 2'd0, 8'd8,  4'd0, 16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    inj_valid = 1'b0; inj_dest = '0; inj_size = '0;
    ack_valid = 1'b0; ack_dest = '0; ack_size = '0;
    ack_pos = 1'b0; ack_ecn = 1'b0;
  endtask

  function automatic int shrink(input int l);
    int s;
    s = (l * 4) / 5;
    return (s < 24) ? 24 : s;
  endfunction

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    for (int d = 0; d < ND; d++) begin
      q_dest = 2'(d);
      #1;
      check("R1 limit", int'(q_limit), MAXW);
      check("R1 occ", int'(q_occ), 0);
    end
  endtask

  task automatic mark_ack(input logic [1:0] d);
    ack_valid = 1'b1; ack_dest = d; ack_ecn = 1'b1; ack_pos = 1'b0; ack_size = '0;
    step(1);
    idle();
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_l;
    buf_occ = '0; fwd_ecn_i = 1'b0; q_dest = '0;
    @(negedge clk);
    do_reset();

    // Table walk: R2, R3, R9
    for (int i = 0; i < 8; i++) begin
      logic [1:0] op;
      op = VEC[i][31:30];
      idle();
      q_dest   = VEC[i][29:28];
      inj_dest = VEC[i][29:28];
      ack_dest = VEC[i][29:28];
      if (op == 2'd0) begin
        inj_valid = 1'b1; inj_size = VEC[i][24:20];
        #1 check("R2 ready in table", int'(inj_ready), 1);
      end else begin
        ack_valid = 1'b1; ack_size = VEC[i][24:20]; ack_pos = (op == 2'd1);
      end
      step(1);
      idle();
      #1;
      check("R2/R3 occ in table", int'(q_occ), int'(VEC[i][15:0]));
      check("R9 limit untouched", int'(q_limit), MAXW);
    end

    // R10 simultaneous injection and positive ack, then R3 saturation
    do_reset();
    q_dest = 2'd0;
    inj_valid = 1'b1; inj_dest = 2'd0; inj_size = 5'd24;
    step(1);
    inj_size = 5'd10;
    ack_valid = 1'b1; ack_dest = 2'd0; ack_size = 5'd24; ack_pos = 1'b1;
    step(1);
    idle(); #1;
    check("R10 same-edge inject and ack", int'(q_occ), 10);
    ack_valid = 1'b1; ack_dest = 2'd0; ack_size = 5'd24; ack_pos = 1'b1;
    step(1);
    idle(); #1;
    check("R3 saturate at zero", int'(q_occ), 0);

    // R2 window fill to the exact limit, then refusal
    q_dest = 2'd2;
    for (int k = 0; k < 170; k++) begin
      inj_valid = 1'b1; inj_dest = 2'd2; inj_size = 5'd24;
      #1;
      if (inj_ready !== 1'b1) check("R2 ready during fill", int'(inj_ready), 1);
      step(1);
    end
    inj_size = 5'd16;
    #1 check("R2 exact fit ready", int'(inj_ready), 1);
    step(1);
    inj_size = 5'd1;
    #1 check("R2 over limit not ready", int'(inj_ready), 0);
    step(1);
    idle(); #1;
    check("R2 refused packet not counted", int'(q_occ), 4096);

    // R4 marked positive ack: count falls, limit shrinks
    ack_valid = 1'b1; ack_dest = 2'd2; ack_size = 5'd24; ack_pos = 1'b1; ack_ecn = 1'b1;
    step(1);
    idle(); #1;
    check("R4 shrink limit", int'(q_limit), 3276);
    check("R3 positive ack with mark", int'(q_occ), 4072);
    inj_valid = 1'b1; inj_dest = 2'd2; inj_size = 5'd1;
    #1 check("R2 count above shrunk limit", int'(inj_ready), 0);
    q_dest = 2'd0; #1;
    check("R9 other destination limit", int'(q_limit), MAXW);
    idle();

    // R4 floor after repeated marked acks
    do_reset();
    q_dest = 2'd3;
    exp_l = MAXW;
    ack_valid = 1'b1; ack_dest = 2'd3; ack_ecn = 1'b1; ack_pos = 1'b0; ack_size = 5'd5;
    for (int k = 0; k < 25; k++) begin
      exp_l = shrink(exp_l);
      step(1);
    end
    idle(); #1;
    check("R4 floor of one packet", int'(q_limit), exp_l);
    check("R3 negative ack leaves count", int'(q_occ), 0);

    // R5, R7, R6 regrowth timing on destination 1
    do_reset();
    q_dest = 2'd1;
    mark_ack(2'd1);                       // edge E
    check("R4 first shrink", int'(q_limit), 3276);
    step(29); #1;                         // after E+29
    check("R5 no growth before period", int'(q_limit), 3276);
    step(1); #1;                          // after E+30
    check("R5 first increment", int'(q_limit), 3277);
    step(9);                              // after E+39
    mark_ack(2'd1);                       // edge E+40
    check("R4 second shrink", int'(q_limit), 2621);
    step(19); #1;                         // after E+59
    check("R7 phase kept, before tick", int'(q_limit), 2621);
    step(1); #1;                          // after E+60
    check("R7 tick at original phase", int'(q_limit), 2622);
    step(29);                             // after E+89
    mark_ack(2'd1);                       // edge E+90, a tick edge
    check("R6 reduction wins over tick", int'(q_limit), 2097);
    step(29); #1;
    check("R6 no extra growth", int'(q_limit), 2097);
    step(1); #1;
    check("R6 next tick still on phase", int'(q_limit), 2098);

    // R5 regrowth to the ceiling and no further
    do_reset();
    q_dest = 2'd1;
    mark_ack(2'd1);
    step(24599); #1;
    check("R5 one below ceiling", int'(q_limit), 4095);
    step(1); #1;
    check("R5 reaches ceiling", int'(q_limit), MAXW);
    step(90); #1;
    check("R5 held at ceiling", int'(q_limit), MAXW);

    // R8 congestion marker around the half-full boundary
    buf_occ = 7'd32; fwd_ecn_i = 1'b0; #1;
    check("R8 half full not congested", int'(congested), 0);
    check("R8 unmarked passes clean", int'(fwd_ecn_o), 0);
    buf_occ = 7'd33; #1;
    check("R8 above half congested", int'(congested), 1);
    check("R8 marks when congested", int'(fwd_ecn_o), 1);
    buf_occ = 7'd64; #1;
    check("R8 full buffer marks", int'(fwd_ecn_o), 1);
    buf_occ = 7'd0; fwd_ecn_i = 1'b1; #1;
    check("R8 incoming mark kept", int'(fwd_ecn_o), 1);
    check("R8 empty not congested", int'(congested), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule